// File: doc/BRIEF.md
# Chainable Serial Configuration Port with Shadow Register

This block is the serial control port of a multi-channel front-end chip. It holds a 53-bit serial path and a 53-bit working register. The working register drives every programmable setting: discriminator threshold and hysteresis, charge-integration gate, rundown current, charge-cell threshold, dead time, calibration capacitor banks and channel mask, channel enables, output forcing and the measurement mode. New settings are shifted in while the applied settings stay unchanged. A load strobe then applies all of them on one clock edge. A capture strobe copies the applied settings back into the serial path so that they can be read out.

The serial output is the top bit of the serial path, retimed on the falling clock edge. The next device in a chain samples it on the rising edge, so the serial output of one device can feed the serial input of the next with no extra timing margin. Many devices then behave as one long shift register, and the chain can be closed into a loop back to the controller. All devices in a chain share the shift-enable, load and capture inputs.

Top module: `cfg_scan_port`

## Requirements
- R1: A synchronous active-high reset sets the working register and the serial path to the same default word. In that word the threshold is 0x36 (bits 52:45), the gate is 0x8 (bits 40:37) and the dead time is 0xC (bits 28:25). Every other bit is 0, so the serial output is 0 after reset.
- R2: A rising edge with shift_en high and capture low moves the serial path one place toward bit 52 and takes sin into bit 0. The following falling edge puts the new bit 52 on sout. A 53-bit word pushed most-significant bit first therefore ends up in place.
- R3: Without a load, the working register and every parameter output keep their value through shifting and through capture.
- R4: A load copies the whole serial path, as it stood before that edge, into the working register on one edge. The outputs take it from the bit fields: thr_code 52:45, hyst_code 44:41, gate_code 40:37, rundown_code 36:33, wilk_thr_code 32:29, dead_code 28:25, cal_a_sel 24:22, cal_b_sel 21:19, cal_mask 18:11, chan_en 10:3, force_sel 2:1, tot_mode 0.
- R5: A capture copies the working register into the serial path, so the next 53 shifts present it on sout, bit 52 first. When capture and shift_en are high on the same edge, the capture wins and no shift takes place.
- R6: When load and capture are high on the same edge, the two registers exchange their contents.
- R7: When load and shift_en are high on the same edge, the working register receives the contents from before the shift, and the serial path still shifts.
- R8: In a chain of two devices, 106 shifts place the first 53 bits pushed in the far device and the last 53 bits in the near device. After a capture, 106 shifts return the combined working contents at the far end of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and register clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift the serial path on this rising edge |
| capture | input | 1 | Copy the working register into the serial path |
| load | input | 1 | Copy the serial path into the working register |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out, changes on the falling edge |
| thr_code | output | 8 | Main discriminator threshold code |
| hyst_code | output | 4 | Discriminator hysteresis code |
| gate_code | output | 4 | Charge integration gate code |
| rundown_code | output | 4 | Charge rundown current code |
| wilk_thr_code | output | 4 | Charge-cell discriminator threshold code |
| dead_code | output | 4 | Dead-time code |
| cal_a_sel | output | 3 | Calibration capacitor bank A select |
| cal_b_sel | output | 3 | Calibration capacitor bank B select |
| cal_mask | output | 8 | Per-channel calibration pulse mask |
| chan_en | output | 8 | Per-channel enables |
| force_sel | output | 2 | Output forcing select |
| tot_mode | output | 1 | 1 selects time-over-threshold, 0 selects charge encoding |

## Verification
Load can share an edge with capture, and it can also share an edge with a shift. Each of these collisions has a fixed outcome. For load with capture, the bench first applies one pattern to the working register, then shifts a second pattern in and pulses both strobes together. It checks that the second pattern appears on the outputs and that the first pattern comes back on the serial readout. For load with shift, the bench checks that the working register holds the contents from before the shift, and that the readout shows the path moved by one bit with the new bit at the bottom. A capture that shares an edge with a shift is judged by reading back the applied word unaltered.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;
  localparam int THR_W  = 8;
  localparam int HYS_W  = 4;
  localparam int GATE_W = 4;
  localparam int RUN_W  = 4;
  localparam int WTH_W  = 4;
  localparam int DEAD_W = 4;
  localparam int CAL_W  = 3;
  localparam int NCH    = 8;
  localparam int FRC_W  = 2;

  // Field order is the serial order: first member sits at the top bit.
  typedef struct packed {
    logic [THR_W-1:0]  thr;
    logic [HYS_W-1:0]  hyst;
    logic [GATE_W-1:0] gate;
    logic [RUN_W-1:0]  rundown;
    logic [WTH_W-1:0]  wthr;
    logic [DEAD_W-1:0] dead;
    logic [CAL_W-1:0]  cal_a;
    logic [CAL_W-1:0]  cal_b;
    logic [NCH-1:0]    cal_mask;
    logic [NCH-1:0]    chan_en;
    logic [FRC_W-1:0]  force_sel;
    logic              tot_mode;
  } cfg_word_t;

  localparam int CFG_W = $bits(cfg_word_t);
endpackage

// File: rtl/cfg_shift_path.sv
module cfg_shift_path #(
  parameter int W = 53,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         capture,
  input  logic         sin,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] sreg_o,
  output logic         sout
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)
      sreg_q <= INIT;
    else if (capture)
      sreg_q <= par_i;
    else if (shift_en)
      sreg_q <= {sreg_q[W-2:0], sin};
  end

  // Retime the top bit on the falling edge for hold-safe chaining.
  always_ff @(negedge clk) begin
    if (rst)
      sout <= INIT[W-1];
    else
      sout <= sreg_q[W-1];
  end

  assign sreg_o = sreg_q;

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !capture) |=> (sreg_q == {$past(sreg_q[W-2:0]), $past(sin)})); // R2
  AST_SOUT_IS_TOP: assert property (@(posedge clk) disable iff (rst)
    sout == sreg_q[W-1]); // R2
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
    capture |=> (sreg_q == $past(par_i))); // R5
  AST_PATH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!capture && !shift_en) |=> $stable(sreg_q)); // R2
endmodule

// File: rtl/cfg_work_reg.sv
module cfg_work_reg #(
  parameter int W = 53,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] sreg_i,
  output logic [W-1:0] work_o
);
  logic [W-1:0] work_q;

  always_ff @(posedge clk) begin
    if (rst)
      work_q <= INIT;
    else if (load)
      work_q <= sreg_i;
  end

  assign work_o = work_q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(work_q)); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    load |=> (work_q == $past(sreg_i))); // R4
endmodule

// File: rtl/cfg_field_split.sv
module cfg_field_split
  import cfg_scan_pkg::*;
(
  input  logic [CFG_W-1:0]  word_i,
  output logic [THR_W-1:0]  thr_code,
  output logic [HYS_W-1:0]  hyst_code,
  output logic [GATE_W-1:0] gate_code,
  output logic [RUN_W-1:0]  rundown_code,
  output logic [WTH_W-1:0]  wilk_thr_code,
  output logic [DEAD_W-1:0] dead_code,
  output logic [CAL_W-1:0]  cal_a_sel,
  output logic [CAL_W-1:0]  cal_b_sel,
  output logic [NCH-1:0]    cal_mask,
  output logic [NCH-1:0]    chan_en,
  output logic [FRC_W-1:0]  force_sel,
  output logic              tot_mode
);
  cfg_word_t f;
  assign f = cfg_word_t'(word_i);

  assign thr_code      = f.thr;
  assign hyst_code     = f.hyst;
  assign gate_code     = f.gate;
  assign rundown_code  = f.rundown;
  assign wilk_thr_code = f.wthr;
  assign dead_code     = f.dead;
  assign cal_a_sel     = f.cal_a;
  assign cal_b_sel     = f.cal_b;
  assign cal_mask      = f.cal_mask;
  assign chan_en       = f.chan_en;
  assign force_sel     = f.force_sel;
  assign tot_mode      = f.tot_mode;
endmodule

// File: rtl/cfg_scan_port.sv
module cfg_scan_port
  import cfg_scan_pkg::*;
#(
  parameter logic [THR_W-1:0]  THR_NOM  = 8'h36,
  parameter logic [GATE_W-1:0] GATE_NOM = 4'h8,
  parameter logic [DEAD_W-1:0] DEAD_NOM = 4'hC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              capture,
  input  logic              load,
  input  logic              sin,
  output logic              sout,
  output logic [THR_W-1:0]  thr_code,
  output logic [HYS_W-1:0]  hyst_code,
  output logic [GATE_W-1:0] gate_code,
  output logic [RUN_W-1:0]  rundown_code,
  output logic [WTH_W-1:0]  wilk_thr_code,
  output logic [DEAD_W-1:0] dead_code,
  output logic [CAL_W-1:0]  cal_a_sel,
  output logic [CAL_W-1:0]  cal_b_sel,
  output logic [NCH-1:0]    cal_mask,
  output logic [NCH-1:0]    chan_en,
  output logic [FRC_W-1:0]  force_sel,
  output logic              tot_mode
);
  localparam cfg_word_t DEF_WORD = '{
    thr: THR_NOM, hyst: '0, gate: GATE_NOM, rundown: '0, wthr: '0,
    dead: DEAD_NOM, cal_a: '0, cal_b: '0, cal_mask: '0, chan_en: '0,
    force_sel: '0, tot_mode: 1'b0};
  localparam logic [CFG_W-1:0] DEF_BITS = DEF_WORD;

  logic [CFG_W-1:0] sreg;
  logic [CFG_W-1:0] work;

  cfg_shift_path #(.W(CFG_W), .INIT(DEF_BITS)) u_path (
    .clk(clk), .rst(rst), .shift_en(shift_en), .capture(capture),
    .sin(sin), .par_i(work), .sreg_o(sreg), .sout(sout));

  cfg_work_reg #(.W(CFG_W), .INIT(DEF_BITS)) u_work (
    .clk(clk), .rst(rst), .load(load), .sreg_i(sreg), .work_o(work));

  cfg_field_split u_split (
    .word_i(work), .thr_code(thr_code), .hyst_code(hyst_code),
    .gate_code(gate_code), .rundown_code(rundown_code),
    .wilk_thr_code(wilk_thr_code), .dead_code(dead_code),
    .cal_a_sel(cal_a_sel), .cal_b_sel(cal_b_sel), .cal_mask(cal_mask),
    .chan_en(chan_en), .force_sel(force_sel), .tot_mode(tot_mode));

  AST_SWAP_ON_BOTH: assert property (@(posedge clk) disable iff (rst)
    (load && capture) |=> (work == $past(sreg) && sreg == $past(work))); // R6
  AST_LOAD_PRESHIFT: assert property (@(posedge clk) disable iff (rst)
    (load && shift_en && !capture) |=> (work == $past(sreg))); // R7
  AST_RESET_DEFAULT: assert property (@(posedge clk)
    rst |=> (work == DEF_BITS && sreg == DEF_BITS)); // R1
endmodule

// File: tb/sim_cfg_scan_port.sv
`timescale 1ns/1ps
module sim_cfg_scan_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, capture = 1'b0, load = 1'b0, sin = 1'b0;
  logic sout0, sout1;
  logic [7:0] thr0, thr1, msk0, msk1, en0, en1;
  logic [3:0] hys0, hys1, gat0, gat1, run0, run1, wth0, wth1, ded0, ded1;
  logic [2:0] ca0, ca1, cb0, cb1;
  logic [1:0] frc0, frc1;
  logic tot0, tot1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_scan_port u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .capture(capture), .load(load),
    .sin(sin), .sout(sout0), .thr_code(thr0), .hyst_code(hys0), .gate_code(gat0),
    .rundown_code(run0), .wilk_thr_code(wth0), .dead_code(ded0), .cal_a_sel(ca0),
    .cal_b_sel(cb0), .cal_mask(msk0), .chan_en(en0), .force_sel(frc0), .tot_mode(tot0));

  cfg_scan_port u1 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .capture(capture), .load(load),
    .sin(sout0), .sout(sout1), .thr_code(thr1), .hyst_code(hys1), .gate_code(gat1),
    .rundown_code(run1), .wilk_thr_code(wth1), .dead_code(ded1), .cal_a_sel(ca1),
    .cal_b_sel(cb1), .cal_mask(msk1), .chan_en(en1), .force_sel(frc1), .tot_mode(tot1));

  localparam logic [52:0] DEF = {8'h36, 4'h0, 4'h8, 4'h0, 4'h0, 4'hC,
                                 3'b0, 3'b0, 8'h00, 8'h00, 2'b00, 1'b0};
  localparam logic [105:0] PAT = {64'hA5C3_0F96_1E2D_7B48, 42'h2B7E15163A9};
  localparam logic [105:0] QAT = {64'h3C5A_96E1_0FF0_1248, 42'h1D4C3B2A1F0};

  function automatic logic [52:0] word0();
    return {thr0, hys0, gat0, run0, wth0, ded0, ca0, cb0, msk0, en0, frc0, tot0};
  endfunction
  function automatic logic [52:0] word1();
    return {thr1, hys1, gat1, run1, wth1, ded1, ca1, cb1, msk1, en1, frc1, tot1};
  endfunction

  task automatic chk(input string tag, input logic [105:0] act, input logic [105:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_chain(input logic [105:0] din, output logic [105:0] dout);
    for (int i = 0; i < 106; i++) begin
      @(negedge clk); #1;
      dout[105-i] = sout1;
      sin = din[105-i];
      shift_en = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); #1;
    shift_en = 1'b0;
    sin = 1'b0;
  endtask

  task automatic strobe(input logic l, input logic c, input logic s, input logic d);
    @(negedge clk); #1;
    load = l; capture = c; shift_en = s; sin = d;
    @(posedge clk);
    @(negedge clk); #1;
    load = 0; capture = 0; shift_en = 0; sin = 0;
  endtask

  task automatic t_reset();
    chk("R1 far device default", {53'b0, word1()}, {53'b0, DEF});
    chk("R1 near device default", {53'b0, word0()}, {53'b0, DEF});
    chk("R1 sout after reset", {105'b0, sout1}, 106'b0);
  endtask

  task automatic t_push_pattern();
    logic [105:0] got;
    shift_chain(PAT, got);
    chk("R1 R2 default path readout", got, {DEF, DEF});
    chk("R3 far outputs hold during shift", {53'b0, word1()}, {53'b0, DEF});
    chk("R3 near outputs hold during shift", {53'b0, word0()}, {53'b0, DEF});
  endtask

  task automatic t_load_chain();
    strobe(1, 0, 0, 0);
    chk("R4 R8 far device gets first half", {53'b0, word1()}, {53'b0, PAT[105:53]});
    chk("R4 R8 near device gets last half", {53'b0, word0()}, {53'b0, PAT[52:0]});
  endtask

  task automatic t_readback();
    logic [105:0] got;
    strobe(0, 1, 0, 0);
    chk("R3 outputs hold on capture", {word1(), word0()}, PAT);
    shift_chain('0, got);
    chk("R5 R8 106-shift readback", got, PAT);
    chk("R3 outputs hold during readback", {word1(), word0()}, PAT);
  endtask

  task automatic t_capture_with_shift();
    logic [105:0] got;
    strobe(0, 1, 1, 1);
    shift_chain('0, got);
    chk("R5 capture beats shift", got, PAT);
  endtask

  task automatic t_load_with_shift();
    logic [105:0] got, dummy;
    shift_chain(QAT, dummy);
    strobe(1, 0, 1, 1);
    chk("R7 far gets pre-shift half", {53'b0, word1()}, {53'b0, QAT[105:53]});
    chk("R7 near gets pre-shift half", {53'b0, word0()}, {53'b0, QAT[52:0]});
    shift_chain('0, got);
    chk("R7 R2 path shifted once", got, {QAT[104:0], 1'b1});
  endtask

  task automatic t_swap();
    logic [105:0] got, dummy;
    shift_chain(PAT, dummy);
    strobe(1, 1, 0, 0);
    chk("R6 outputs take path contents", {word1(), word0()}, PAT);
    shift_chain('0, got);
    chk("R6 path takes old working word", got, QAT);
    chk("R3 outputs hold after swap readout", {word1(), word0()}, PAT);
  endtask

  task automatic t_mid_reset();
    logic [105:0] got;
    @(negedge clk); #1; rst = 1'b1;
    @(posedge clk); @(negedge clk); #1; rst = 1'b0;
    chk("R1 reset restores defaults", {word1(), word0()}, {DEF, DEF});
    shift_chain('0, got);
    chk("R1 reset restores path", got, {DEF, DEF});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    t_reset();
    t_push_pattern();
    t_load_chain();
    t_readback();
    t_capture_with_shift();
    t_load_with_shift();
    t_swap();
    t_mid_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule